// File: doc/BRIEF.md
# Recent-Translation Shift Cache

This block holds a handful of the most recent virtual-to-physical page translations so that a pipeline can skip a full translation for pages it touched a moment ago. It keeps two independent lists, one fed by instruction fetches and one by data accesses. Each list has its own depth. Every insertion puts the new translation at the front and moves everything else back one slot, so the list is always ordered from newest to oldest. The oldest slot is simply dropped.

A lookup presents a virtual address, the list to search and whether the access is a write. All slots of the chosen list are compared at once. The answer comes back one clock later: a hit flag, the 4 KiB-aligned physical page base, and the permission code recorded when the translation was inserted. A global bypass input freezes both lists against insertion. Walking page tables and raising faults are left to the surrounding logic.

Top module: `xlat_shift_cache`

## Requirements
- R1: After synchronous reset every slot in both lists is invalid (code 0), so every lookup misses; `rsp_valid`, `rsp_hit`, `rsp_pbase` and `rsp_perm` read 0 while reset is held.
- R2: A lookup presented with `lk_valid` high in one cycle is answered in the next cycle with `rsp_valid` high. A cycle with `lk_valid` low is followed by `rsp_valid`, `rsp_hit`, `rsp_pbase` and `rsp_perm` all 0. A miss returns `rsp_pbase` and `rsp_perm` equal to 0.
- R3: Pages are 4 KiB. Only address bits [VA_W-1:12] take part in matching, so the low 12 bits of `lk_vaddr` and `ins_vaddr` have no effect. `rsp_pbase` is the inserted `ins_paddr` with bits [11:0] forced to 0.
- R4: An accepted insert writes the new translation to slot 0 and moves slot i to slot i+1. The translation in the last slot is discarded, so a page misses once as many newer inserts as the list depth have gone into the same list.
- R5: `ins_instr`=1 inserts into the instruction list and `ins_instr`=0 inserts into the data list. `lk_instr` selects the list searched in the same way. An insert into one list is never visible to lookups of the other list.
- R6: The stored permission code is 1 when `ins_write`=0 and 2 when `ins_write`=1. On a hit it is returned on `rsp_perm`. Code 0 marks an empty slot.
- R7: A lookup with `lk_write`=1 hits only a slot with code 2. A lookup with `lk_write`=0 hits a slot with code 1 or 2.
- R8: When several valid slots match, the one with the lowest index, which is the newest, supplies the result.
- R9: While `bypass` is high an insert changes nothing: the new page is not found, and the existing slots are neither shifted nor lost.
- R10: A lookup in the same cycle as an insert into the same list sees the contents from before that insert.
- R11: The instruction list holds `DEPTH_I` slots and the data list holds `DEPTH_D` slots, and each list ages on its own inserts only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Blocks all inserts while high |
| ins_valid | input | 1 | Insert request |
| ins_instr | input | 1 | Insert target: 1 instruction list, 0 data list |
| ins_write | input | 1 | Insert came from a write access (code 2) rather than a read (code 1) |
| ins_vaddr | input | VA_W | Virtual address of the translated access |
| ins_paddr | input | PA_W | Physical address of the translated access |
| lk_valid | input | 1 | Lookup request |
| lk_instr | input | 1 | Lookup list: 1 instruction, 0 data |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vaddr | input | VA_W | Virtual address to translate |
| rsp_valid | output | 1 | Response to the previous cycle's lookup |
| rsp_hit | output | 1 | Translation found |
| rsp_pbase | output | PA_W | Physical page base, low 12 bits zero |
| rsp_perm | output | 2 | Stored permission code of the hit slot |

## Verification
The properties assume that `lk_write` and `lk_valid` are stable across the clock edge that samples them. They also assume that reset is held for at least one edge before any request is made. The bench meets both by changing every input only on the falling clock edge and by applying reset for several cycles at the start and again midway.

The bench replays insert streams with repeating page numbers across both lists. It uses a small configuration with unequal depths. After every insert it sweeps lookups over all page numbers in use, for both lists and both access kinds. Every response is compared with a newest-first list model kept in the bench.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Byte offset width inside one 4 KiB page.
    localparam int PAGE_SHIFT = 12;

    // Permission code stored alongside every slot.
    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RD   = 2'd1,
        PERM_WR   = 2'd2
    } perm_e;

    // Code recorded for an insert caused by a read or a write access.
    function automatic perm_e perm_of_access(input logic is_write);
        return is_write ? PERM_WR : PERM_RD;
    endfunction

    // Does a slot carrying code p satisfy an access of the given kind?
    function automatic logic perm_grants(input perm_e p, input logic want_write);
        if (want_write)
            return p == PERM_WR;
        return p != PERM_NONE;
    endfunction

endpackage

// File: rtl/xlat_shift_list.sv
module xlat_shift_list
    import xlat_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int VPN_W = 20,
    parameter int PFN_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push,
    input  logic [VPN_W-1:0]        push_vpn,
    input  logic [PFN_W-1:0]        push_pfn,
    input  perm_e                   push_perm,
    input  logic [VPN_W-1:0]        look_vpn,
    input  logic                    look_write,
    output logic [DEPTH-1:0]        match_vec,
    output logic [DEPTH*PFN_W-1:0]  pfn_flat,
    output logic [DEPTH*2-1:0]      perm_flat
);

    typedef struct packed {
        perm_e             perm;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
    } slot_t;

    slot_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_t next_slot;

        if (g == 0) begin : g_head
            always_comb begin
                next_slot.perm = push_perm;
                next_slot.vpn  = push_vpn;
                next_slot.pfn  = push_pfn;
            end
        end else begin : g_body
            always_comb next_slot = slots[g-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g].perm <= PERM_NONE;
                slots[g].vpn  <= '0;
                slots[g].pfn  <= '0;
            end else if (push) begin
                slots[g] <= next_slot;
            end
        end

        assign match_vec[g] = perm_grants(slots[g].perm, look_write)
                              && (slots[g].vpn == look_vpn);
        assign pfn_flat[g*PFN_W +: PFN_W] = slots[g].pfn;
        assign perm_flat[g*2 +: 2]        = slots[g].perm;
    end

endmodule

// File: rtl/xlat_first_hit.sv
module xlat_first_hit #(
    parameter int DEPTH = 4,
    parameter int PFN_W = 20
) (
    input  logic [DEPTH-1:0]        match_vec,
    input  logic [DEPTH*PFN_W-1:0]  pfn_flat,
    input  logic [DEPTH*2-1:0]      perm_flat,
    output logic                    hit,
    output logic [PFN_W-1:0]        pfn,
    output logic [1:0]              perm
);

    // Walk from the oldest slot to the newest so the lowest index wins.
    always_comb begin
        hit  = 1'b0;
        pfn  = '0;
        perm = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit  = 1'b1;
                pfn  = pfn_flat[i*PFN_W +: PFN_W];
                perm = perm_flat[i*2 +: 2];
            end
        end
    end

endmodule

// File: rtl/xlat_shift_cache.sv
module xlat_shift_cache
    import xlat_pkg::*;
#(
    parameter int DEPTH_I = 4,
    parameter int DEPTH_D = 4,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bypass,
    input  logic             ins_valid,
    input  logic             ins_instr,
    input  logic             ins_write,
    input  logic [VA_W-1:0]  ins_vaddr,
    input  logic [PA_W-1:0]  ins_paddr,
    input  logic             lk_valid,
    input  logic             lk_instr,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PA_W-1:0]  rsp_pbase,
    output logic [1:0]       rsp_perm
);

    localparam int VPN_W  = VA_W - PAGE_SHIFT;
    localparam int PFN_W  = PA_W - PAGE_SHIFT;
    localparam int N_LIST = 2;  // index 0: instruction, index 1: data

    logic [VPN_W-1:0] ins_vpn;
    logic [PFN_W-1:0] ins_pfn;
    logic [VPN_W-1:0] lk_vpn;
    perm_e            ins_code;
    logic             ins_ok;

    assign ins_vpn  = ins_vaddr[VA_W-1:PAGE_SHIFT];
    assign ins_pfn  = ins_paddr[PA_W-1:PAGE_SHIFT];
    assign lk_vpn   = lk_vaddr[VA_W-1:PAGE_SHIFT];
    assign ins_code = perm_of_access(ins_write);
    assign ins_ok   = ins_valid && !bypass;

    logic [N_LIST-1:0] side_hit;
    logic [PFN_W-1:0]  side_pfn  [N_LIST];
    logic [1:0]        side_perm [N_LIST];

    for (genvar s = 0; s < N_LIST; s++) begin : g_list
        localparam int  DEP     = (s == 0) ? DEPTH_I : DEPTH_D;
        localparam logic IS_INS = (s == 0);

        logic                   push;
        logic [DEP-1:0]         match_vec;
        logic [DEP*PFN_W-1:0]   pfn_flat;
        logic [DEP*2-1:0]       perm_flat;

        assign push = ins_ok && (ins_instr == IS_INS);

        xlat_shift_list #(
            .DEPTH (DEP),
            .VPN_W (VPN_W),
            .PFN_W (PFN_W)
        ) u_list (
            .clk        (clk),
            .rst        (rst),
            .push       (push),
            .push_vpn   (ins_vpn),
            .push_pfn   (ins_pfn),
            .push_perm  (ins_code),
            .look_vpn   (lk_vpn),
            .look_write (lk_write),
            .match_vec  (match_vec),
            .pfn_flat   (pfn_flat),
            .perm_flat  (perm_flat)
        );

        xlat_first_hit #(
            .DEPTH (DEP),
            .PFN_W (PFN_W)
        ) u_pick (
            .match_vec (match_vec),
            .pfn_flat  (pfn_flat),
            .perm_flat (perm_flat),
            .hit       (side_hit[s]),
            .pfn       (side_pfn[s]),
            .perm      (side_perm[s])
        );
    end

    logic             sel_hit;
    logic [PFN_W-1:0] sel_pfn;
    logic [1:0]       sel_perm;

    always_comb begin
        if (lk_instr) begin
            sel_hit  = side_hit[0];
            sel_pfn  = side_pfn[0];
            sel_perm = side_perm[0];
        end else begin
            sel_hit  = side_hit[1];
            sel_pfn  = side_pfn[1];
            sel_perm = side_perm[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pbase <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && sel_hit;
            rsp_pbase <= (lk_valid && sel_hit) ? {sel_pfn, {PAGE_SHIFT{1'b0}}} : '0;
            rsp_perm  <= (lk_valid && sel_hit) ? sel_perm : 2'd0;
        end
    end

endmodule

// File: rtl/xlat_shift_cache_chk.sv
module xlat_shift_cache_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic            lk_write,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic [PA_W-1:0] rsp_pbase,
    input logic [1:0]      rsp_perm
);

    assert_answer_follows_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> (!rsp_valid && !rsp_hit && rsp_pbase == '0 && rsp_perm == 2'd0));

    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_pbase == '0 && rsp_perm == 2'd0));

    assert_hit_code_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> (rsp_perm == 2'd1 || rsp_perm == 2'd2));

    assert_write_needs_wr_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_hit && $past(lk_write)) |-> rsp_perm == 2'd2);

endmodule

bind xlat_shift_cache xlat_shift_cache_chk #(.PA_W(PA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_write  (lk_write),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_pbase (rsp_pbase),
    .rsp_perm  (rsp_perm)
);

// File: tb/xlat_shift_cache_tb.sv
module xlat_shift_cache_tb;

    localparam int DI = 4;
    localparam int DD = 3;
    localparam int MAXD = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        bypass;
    logic        ins_valid, ins_instr, ins_write;
    logic [31:0] ins_vaddr, ins_paddr;
    logic        lk_valid, lk_instr, lk_write;
    logic [31:0] lk_vaddr;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_pbase;
    logic [1:0]  rsp_perm;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    // Newest-first model: list 0 instruction, list 1 data.
    logic [19:0] m_vpn  [2][MAXD];
    logic [19:0] m_pfn  [2][MAXD];
    logic [1:0]  m_perm [2][MAXD];
    int          m_dep  [2];

    always #2 clk = ~clk;

    xlat_shift_cache #(
        .DEPTH_I (DI),
        .DEPTH_D (DD),
        .VA_W    (32),
        .PA_W    (32)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bypass    (bypass),
        .ins_valid (ins_valid),
        .ins_instr (ins_instr),
        .ins_write (ins_write),
        .ins_vaddr (ins_vaddr),
        .ins_paddr (ins_paddr),
        .lk_valid  (lk_valid),
        .lk_instr  (lk_instr),
        .lk_write  (lk_write),
        .lk_vaddr  (lk_vaddr),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_pbase (rsp_pbase),
        .rsp_perm  (rsp_perm)
    );

    task automatic model_clear();
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < MAXD; i++) begin
                m_vpn[s][i]  = '0;
                m_pfn[s][i]  = '0;
                m_perm[s][i] = 2'd0;
            end
    endtask

    task automatic model_push(input logic instr, input logic wr,
                              input logic [31:0] va, input logic [31:0] pa);
        int s = instr ? 0 : 1;
        for (int i = m_dep[s] - 1; i > 0; i--) begin
            m_vpn[s][i]  = m_vpn[s][i-1];
            m_pfn[s][i]  = m_pfn[s][i-1];
            m_perm[s][i] = m_perm[s][i-1];
        end
        m_vpn[s][0]  = va[31:12];
        m_pfn[s][0]  = pa[31:12];
        m_perm[s][0] = wr ? 2'd2 : 2'd1;
    endtask

    task automatic model_find(input logic instr, input logic wr, input logic [31:0] va,
                              output logic hit, output logic [31:0] pb, output logic [1:0] pm);
        int s = instr ? 0 : 1;
        hit = 1'b0; pb = '0; pm = 2'd0;
        for (int i = 0; i < m_dep[s]; i++) begin
            if (!hit && m_vpn[s][i] == va[31:12] && m_perm[s][i] != 2'd0
                && (!wr || m_perm[s][i] == 2'd2)) begin
                hit = 1'b1;
                pb  = {m_pfn[s][i], 12'h000};
                pm  = m_perm[s][i];
            end
        end
    endtask

    // One clock: optional lookup and optional insert driven together.
    task automatic cycle(input logic lv, input logic li, input logic lw, input logic [31:0] lva,
                         input logic iv, input logic ii, input logic iw,
                         input logic [31:0] iva, input logic [31:0] ipa,
                         input logic byp, input string tag);
        logic        e_hit;
        logic [31:0] e_pb;
        logic [1:0]  e_pm;
        @(negedge clk);
        lk_valid = lv; lk_instr = li; lk_write = lw; lk_vaddr = lva;
        ins_valid = iv; ins_instr = ii; ins_write = iw;
        ins_vaddr = iva; ins_paddr = ipa; bypass = byp;
        if (lv) model_find(li, lw, lva, e_hit, e_pb, e_pm);
        else begin e_hit = 1'b0; e_pb = '0; e_pm = 2'd0; end
        if (iv && !byp) model_push(ii, iw, iva, ipa);
        @(posedge clk);
        #1;
        vectors++;
        if (rsp_valid !== lv || rsp_hit !== e_hit || rsp_pbase !== e_pb || rsp_perm !== e_pm) begin
            fails++;
            $display("FAIL %s: got v=%0b hit=%0b pbase=%h perm=%0d exp v=%0b hit=%0b pbase=%h perm=%0d",
                     tag, rsp_valid, rsp_hit, rsp_pbase, rsp_perm, lv, e_hit, e_pb, e_pm);
        end
    endtask

    task automatic lookup(input logic li, input logic lw, input logic [31:0] va, input string tag);
        cycle(1'b1, li, lw, va, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, tag);
    endtask

    task automatic insert(input logic ii, input logic iw, input logic [31:0] va,
                          input logic [31:0] pa, input logic byp, input string tag);
        cycle(1'b0, 1'b0, 1'b0, '0, 1'b1, ii, iw, va, pa, byp, tag);
    endtask

    // Lookups of every page number in use, both lists, both access kinds.
    task automatic sweep(input int salt, input string tag);
        for (int li = 0; li < 2; li++)
            for (int lw = 0; lw < 2; lw++)
                for (int v = 0; v < 14; v++) begin
                    logic [19:0] vpn = (v < 7) ? 20'(v) : 20'(v - 7 + 16);
                    lookup(1'(li), 1'(lw), {vpn, 12'((v * 311 + salt * 17) & 12'hfff)}, tag);
                end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_pbase !== '0 || rsp_perm !== 2'd0) begin
            fails++;
            $display("FAIL R1 reset outputs: got v=%0b hit=%0b pbase=%h perm=%0d exp all 0",
                     rsp_valid, rsp_hit, rsp_pbase, rsp_perm);
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, exp end of stimulus");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        m_dep[0] = DI;
        m_dep[1] = DD;
        rst = 1'b1; bypass = 1'b0;
        ins_valid = 1'b0; ins_instr = 1'b0; ins_write = 1'b0; ins_vaddr = '0; ins_paddr = '0;
        lk_valid = 1'b0; lk_instr = 1'b0; lk_write = 1'b0; lk_vaddr = '0;

        do_reset();
        sweep(0, "R1 empty after reset");

        // Streams with repeating pages; a few inserts blocked by bypass.
        for (int k = 0; k < 28; k++) begin
            logic        ii  = (k % 3 == 0);
            logic        iw  = (k % 4 == 1) || (k % 4 == 2);
            logic [19:0] vpn = 20'((k * 5) % 7 + 16 * (k % 2));
            logic        byp = (k == 9) || (k == 10) || (k == 17);
            insert(ii, iw, {vpn, 12'((k * 53) & 12'hfff)}, {20'(k * 1234 + 77), 12'((k * 91) & 12'hfff)},
                   byp, byp ? "R9 blocked insert" : "R4 insert");
            sweep(k, byp ? "R9 lists unchanged under bypass" : "R4 R5 R7 R8 R11 sweep");
        end

        // Idle cycle: no response.
        cycle(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R2 idle");

        do_reset();
        // Code and page base, offset bits ignored.
        insert(1'b0, 1'b0, 32'h00123_456, 32'hABCDE_FFF, 1'b0, "R6 read insert");
        lookup(1'b0, 1'b0, 32'h00123_001, "R3 R6 read hit, offset ignored");
        lookup(1'b0, 1'b1, 32'h00123_456, "R7 write lookup misses read code");
        lookup(1'b1, 1'b0, 32'h00123_456, "R5 other list misses");
        insert(1'b0, 1'b1, 32'h00123_000, 32'h11111_222, 1'b0, "R6 write insert");
        lookup(1'b0, 1'b0, 32'h00123_FFF, "R8 newest duplicate wins");
        insert(1'b0, 1'b0, 32'h00123_800, 32'h22222_000, 1'b0, "R6 read insert again");
        lookup(1'b0, 1'b0, 32'h00123_000, "R8 newest read entry");
        lookup(1'b0, 1'b1, 32'h00123_000, "R7 R8 write skips read entry");
        // Data list ages out after DD newer inserts.
        for (int j = 0; j < DD; j++) begin
            insert(1'b0, 1'b1, {20'h00200 + 20'(j), 12'h0}, {20'h30000 + 20'(j), 12'h0}, 1'b0, "R11 fill data");
            lookup(1'b0, 1'b1, 32'h00123_000, "R11 data depth ageing");
        end
        // Instruction list ages out after DI newer inserts.
        for (int j = 0; j <= DI; j++) begin
            insert(1'b1, 1'b0, {20'h00050 + 20'(j), 12'h0}, {20'h40000 + 20'(j), 12'h0}, 1'b0, "R4 fill instr");
            lookup(1'b1, 1'b0, 32'h00050_000, "R4 oldest dropped");
        end
        lookup(1'b0, 1'b0, 32'h00201_000, "R5 R11 data list untouched");
        // Same-cycle insert and lookup.
        cycle(1'b1, 1'b0, 1'b0, 32'h00077_000, 1'b1, 1'b0, 1'b0, 32'h00077_000, 32'h77777_000, 1'b0,
              "R10 lookup sees old state");
        lookup(1'b0, 1'b0, 32'h00077_000, "R10 then hits");
        cycle(1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, "R2 idle after hit");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule